// File: doc/BRIEF.md
# Zero-Turnaround Burst Synchronous SRAM

A synchronous single-port memory whose words are 36 bits wide, split into four 9-bit lanes (8 data bits plus a parity bit). All control, address and write data are taken on the rising clock edge. Reads are flow-through: the word appears at the data output right after the edge that registers its address. Write data follows its command by exactly one enabled clock. Because of this, any mix of reads and writes can be issued on consecutive clocks with no idle cycles between them.

A load cycle gives a new external address. A continue cycle steps the two low address bits from an internal 2-bit counter, so that one loaded address serves four accesses. The counter runs in linear order or in interleaved order, and the order is chosen at load time. A clock enable freezes the whole block. Three chip selects gate new accesses. An asynchronous output enable gates only the output drive flag, which stands in for a tristate pad. The depth is set by the address-width parameter.

Top module: `zt_burst_sram`

## Requirements
- R1: After reset the block is deselected: `dout_drive` is 0 and `dout` is all zeros.
- R2: At an enabled edge with `ld_n`=0, all selects active (`cs1_n`=0, `cs2`=1, `cs3_n`=0) and `wr_n`=1, the word at `addr` appears on `dout` right after that edge, and `dout_drive` is 1 while `oe_n`=0.
- R3: A write command taken at an enabled edge commits `din` at the next enabled edge. Lane i is bits [9i+8:9i]. Only lanes whose `lane_wr_n[i]` was 0 with the command are written; the other lanes keep their contents.
- R4: A read loaded on the clock right after a write to the same address returns the newly written word, with no idle cycle in between.
- R5: A cycle with `ld_n`=1 continues the current access. With `burst_ilv`=0 at load, the n-th continuation uses low bits (base+n) mod 4, and the upper address bits stay fixed.
- R6: With `burst_ilv`=1 at load, the n-th continuation uses low bits base XOR n.
- R7: The burst counter wraps after four accesses: the fourth continuation returns to the loaded address.
- R8: While `clk_en_n`=1, no address, burst, write or output state changes, and `din` is not written. Stalled cycles do not count toward the write data delay.
- R9: A load cycle with any select inactive deselects the block: `dout_drive` goes to 0 after that edge, nothing is written, and continue cycles leave the block deselected.
- R10: During any write access, including burst continuations, `dout_drive` is 0 even with `oe_n`=0.
- R11: `oe_n`=1 forces `dout_drive` to 0 and `dout` to zero without a clock edge and without changing state. Returning to 0 shows the read data again.
- R12: A write burst writes each stepped address with the `din` of the following enabled edge, under the lane mask sampled with each continuation cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Clock enable, active low; 1 freezes the block |
| ld_n | input | 1 | 0 loads a new address, 1 continues the burst |
| wr_n | input | 1 | 0 makes a loaded access a write |
| lane_wr_n | input | 4 | Per-lane write select, active low |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not driven |
| dout_drive | output | 1 | High when read data would be driven |

## Verification
A wrong burst counter or a wrong order selection shows on `dout` in the same cycle it happens, because reads are flow-through and a single wrong continuation returns the neighbouring word. A write pipeline that is off by one cycle, or that keeps counting during stalls, stores the wrong `din`. That error stays hidden until the address is read back, so every write is followed by a read at once or within a short sweep. Errors in deselect or output enable show directly on `dout_drive` one edge after the command, or at once for `oe_n`.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef logic [LANES-1:0]   lane_mask_t;
    typedef logic [BURST_W-1:0] burst_t;

    // Current access held between enabled edges
    typedef struct packed {
        logic       live;    // a selected access is in progress
        logic       is_wr;   // access is a write
        logic       ilv;     // interleaved burst order
        burst_t     step;    // burst position
        lane_mask_t keep_n;  // active-low lane write selects
    } acc_t;

    function automatic burst_t burst_low(input burst_t start, input burst_t step,
                                         input logic ilv);
        return ilv ? (start ^ step) : burst_t'(start + step);
    endfunction

endpackage

// File: rtl/zt_access_ctl.sv
module zt_access_ctl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  logic              load,
    input  logic              selected,
    input  logic              wr_req,
    input  logic              ilv_in,
    input  lane_mask_t        lane_n,
    input  logic [ADDR_W-1:0] addr_in,
    output acc_t              acc,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            base_q <= '0;
        end else if (adv_en) begin
            if (load) begin
                if (selected) begin
                    acc.live   <= 1'b1;
                    acc.is_wr  <= wr_req;
                    acc.ilv    <= ilv_in;
                    acc.step   <= '0;
                    acc.keep_n <= lane_n;
                    base_q     <= addr_in;
                end else begin
                    acc.live   <= 1'b0;
                end
            end else if (acc.live) begin
                acc.step   <= burst_t'(acc.step + 1'b1);
                acc.keep_n <= lane_n;
            end
        end
    end

    assign eff_addr = {base_q[ADDR_W-1:BURST_W],
                       burst_low(base_q[BURST_W-1:0], acc.step, acc.ilv)};

endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    // Flow-through: read follows the registered access address
    assign rdata = cells[addr];

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              ld_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              burst_ilv,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_drive
);

    acc_t              acc;
    logic [ADDR_W-1:0] eff_addr;
    logic              selected;
    logic              commit;
    logic [WORD_W-1:0] rd_word;

    assign selected = !cs1_n && cs2 && !cs3_n;

    zt_access_ctl #(.ADDR_W(ADDR_W)) i_ctl (
        .clk      (clk),
        .rst      (rst),
        .adv_en   (!clk_en_n),
        .load     (!ld_n),
        .selected (selected),
        .wr_req   (!wr_n),
        .ilv_in   (burst_ilv),
        .lane_n   (lane_wr_n),
        .addr_in  (addr),
        .acc      (acc),
        .eff_addr (eff_addr)
    );

    // Data of the write held in acc arrives on the next enabled edge
    assign commit = !clk_en_n && acc.live && acc.is_wr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        zt_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_lane (
            .clk   (clk),
            .we    (commit && !acc.keep_n[g]),
            .addr  (eff_addr),
            .wdata (din[g*LANE_W +: LANE_W]),
            .rdata (rd_word[g*LANE_W +: LANE_W])
        );
    end

    assign dout_drive = acc.live && !acc.is_wr && !oe_n;
    assign dout       = dout_drive ? rd_word : '0;

endmodule

// File: rtl/zt_sram_checks.sv
module zt_sram_checks
    import zt_sram_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              ld_n,
    input logic              wr_n,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              oe_n,
    input logic [WORD_W-1:0] dout,
    input logic              dout_drive
);

    logic sel_all;
    assign sel_all = !cs1_n && cs2 && !cs3_n;

    assert_load_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !ld_n && sel_all && wr_n) |=> (oe_n || dout_drive));

    assert_stall_freezes_R8: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ((oe_n != $past(oe_n)) || ($stable(dout) && $stable(dout_drive))));

    assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !ld_n && !sel_all) |=> !dout_drive);

    assert_write_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !ld_n && sel_all && !wr_n) |=> !dout_drive);

    assert_oe_gates_R11: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_drive);

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !dout_drive |-> (dout == '0));

endmodule

bind zt_burst_sram zt_sram_checks i_checks (
    .clk        (clk),
    .rst        (rst),
    .clk_en_n   (clk_en_n),
    .ld_n       (ld_n),
    .wr_n       (wr_n),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .oe_n       (oe_n),
    .dout       (dout),
    .dout_drive (dout_drive)
);

// File: tb/test_zt_burst_sram.sv
module test_zt_burst_sram;

    localparam int AW = 8;
    localparam int NW = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en_n = 1'b0;
    logic        ld_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic        burst_ilv = 1'b0;
    logic        cs1_n = 1'b0;
    logic        cs2 = 1'b1;
    logic        cs3_n = 1'b0;
    logic        oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_drive;

    int vectors = 0;
    int misses  = 0;

    // Bench reference state
    logic [35:0] ref_mem [NW];
    logic        m_live = 1'b0, m_wr = 1'b0, m_ilv = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]  m_step = '0;
    logic [3:0]  m_keep = 4'hF;

    always #2 clk = ~clk;

    zt_burst_sram #(.ADDR_W(AW)) i_zt_burst_sram (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .ld_n(ld_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .burst_ilv(burst_ilv), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
        .dout_drive(dout_drive)
    );

    function automatic logic [35:0] pat(input int a, input int salt);
        return 36'(a) * 36'h0_1357_9BDF ^ 36'(salt) * 36'h9_8765_4321 ^ 36'hA_5A5A_5A5A;
    endfunction

    function automatic logic [AW-1:0] m_eff();
        logic [1:0] lo;
        lo = m_ilv ? (m_base[1:0] ^ m_step) : 2'(m_base[1:0] + m_step);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check_out(input string tag);
        logic        e_drv;
        logic [35:0] e_dat;
        e_drv = m_live && !m_wr && !oe_n;
        e_dat = e_drv ? ref_mem[m_eff()] : 36'h0;
        vectors++;
        if (dout_drive !== e_drv || dout !== e_dat) begin
            misses++;
            $display("FAIL %s: drive=%0b dout=%h expected drive=%0b dout=%h",
                     tag, dout_drive, dout, e_drv, e_dat);
        end
    endtask

    // One clock: drive inputs, take the edge, update the reference, check
    task automatic cyc(input string tag, input logic cen_i, input logic ld_i,
                       input logic wr_i, input logic [3:0] lw_i, input logic ilv_i,
                       input int sel_i, input logic [AW-1:0] a_i, input logic [35:0] d_i);
        clk_en_n = cen_i; ld_n = ld_i; wr_n = wr_i; lane_wr_n = lw_i;
        burst_ilv = ilv_i; addr = a_i; din = d_i;
        cs1_n = (sel_i == 1); cs2 = (sel_i != 2); cs3_n = (sel_i == 3);
        @(posedge clk); #1;
        if (!cen_i) begin
            if (m_live && m_wr)
                for (int l = 0; l < 4; l++)
                    if (!m_keep[l]) ref_mem[m_eff()][l*9 +: 9] = d_i[l*9 +: 9];
            if (!ld_i) begin
                if (sel_i == 0) begin
                    m_live = 1'b1; m_wr = !wr_i; m_ilv = ilv_i;
                    m_base = a_i; m_step = 2'd0; m_keep = lw_i;
                end else begin
                    m_live = 1'b0;
                end
            end else if (m_live) begin
                m_step = m_step + 2'd1;
                m_keep = lw_i;
            end
        end
        check_out(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_out("R1");

        // Fill with back-to-back writes (R3/R4: data follows by one clock)
        for (int a = 0; a < NW; a++)
            cyc("R3", 0, 0, 0, 4'h0, 0, 0, AW'(a), (a == 0) ? 36'h0 : pat(a - 1, 0));
        cyc("R4", 0, 0, 1, 4'hF, 0, 0, '0, pat(NW - 1, 0));

        // Single-read sweep
        for (int a = 0; a < NW; a++)
            cyc("R2", 0, 0, 1, 4'hF, 0, 0, AW'(a), 36'h0);

        // Alternating write/read with every lane mask
        for (int i = 0; i < 32; i++) begin
            cyc("R10", 0, 0, 0, 4'(i), 0, 0, AW'(i * 7 + 3), 36'h0);
            cyc((i < 16) ? "R3" : "R4", 0, 0, 1, 4'hF, 0, 0, AW'(i * 7 + 3), pat(i, 5));
        end

        // Read bursts, both orders, every start offset, run past the wrap
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++) begin
                cyc("R2", 0, 0, 1, 4'hF, m[0], 0, AW'(8'h40 + s), 36'h0);
                for (int j = 1; j <= 5; j++)
                    cyc((j >= 4) ? "R7" : (m == 1 ? "R6" : "R5"),
                        0, 1, 1, 4'hF, 0, 0, AW'(8'h77), 36'h0);
            end

        // Write bursts with varying lane masks, then read back
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++) begin
                cyc("R12", 0, 0, 0, 4'h0, m[0], 0, AW'(8'h80 + s + 4 * (2 * s + m)), 36'h0);
                for (int j = 1; j <= 3; j++)
                    cyc("R12", 0, 1, 1, 4'(j * 5 + s), 0, 0, '0, pat(j, 10 + s + m));
                cyc("R12", 0, 0, 1, 4'hF, m[0], 0, AW'(8'h80 + s + 4 * (2 * s + m)), pat(4, 10 + s + m));
                for (int j = 1; j <= 3; j++)
                    cyc("R12", 0, 1, 1, 4'hF, 0, 0, '0, 36'h0);
            end

        // Clock-enable stalls: state and write delay frozen
        cyc("R8", 0, 0, 1, 4'hF, 0, 0, AW'(8'h10), 36'h0);
        for (int k = 0; k < 3; k++)
            cyc("R8", 1, 0, 0, 4'h0, 1, 0, AW'(8'hF0 + k), pat(k, 33));
        cyc("R8", 0, 0, 0, 4'h0, 0, 0, AW'(8'h11), 36'h0);
        for (int k = 0; k < 3; k++)
            cyc("R8", 1, 1, 1, 4'h0, 0, 0, '0, pat(k, 44));
        cyc("R8", 0, 0, 1, 4'hF, 0, 0, AW'(8'h11), pat(1, 55));
        cyc("R8", 0, 1, 1, 4'hF, 0, 0, '0, 36'h0);

        // Deselect through each select in turn
        for (int sl = 1; sl <= 3; sl++) begin
            cyc("R9", 0, 0, 0, 4'h0, 0, sl, AW'(8'h20 + sl), 36'h0);
            cyc("R9", 0, 1, 1, 4'h0, 0, 0, '0, pat(sl, 66));
            cyc("R9", 0, 1, 0, 4'h0, 0, 0, '0, pat(sl, 77));
            cyc("R9", 0, 0, 1, 4'hF, 0, 0, AW'(8'h20 + sl), 36'h0);
        end

        // Asynchronous output enable
        cyc("R11", 0, 0, 1, 4'hF, 0, 0, AW'(8'h33), 36'h0);
        oe_n = 1'b1; #1;
        check_out("R11");
        oe_n = 1'b0; #1;
        check_out("R11");
        cyc("R11", 0, 1, 1, 4'hF, 0, 0, '0, 36'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule